// File: doc/BRIEF.md
# Embedded Sync Code Frame Decoder

This block recovers frame and line timing from an 8-bit camera byte stream that has no separate sync wires. Timing is carried in-band as four-byte markers: an all-ones byte, two all-zero bytes, then a tag byte. The tag byte is compared against four programmable values, one each for frame start, frame end, line start and line end. Because 0x00 and 0xFF never occur as pixel values, the decoder can drop every reserved byte from the pixel path and forward only real pixels.

After enable, the decoder stays disarmed until it has seen a frame-end marker followed by a frame-start marker, so capture always begins on a clean frame boundary. From then on, pixel bytes are forwarded only between a line-start marker and the next line-end marker inside an active frame. Accepted frame and line events are reported as one-cycle pulses. Configuration values are plain inputs and are expected to be held steady while capture runs.

Top module: `embsync_decoder`

## Requirements
- R1: While reset is asserted and right after it, outValid and all four event pulses are 0.
- R2: A marker is four consecutive valid bytes 0xFF, 0x00, 0x00, tag. Cycles with inValid low between them neither break nor advance the match.
- R3: A 0xFF byte during a partial match restarts the search with that byte as the first preamble byte. A partial match broken by any other byte is dropped.
- R4: The tag is classified with the priority frame start, then frame end, then line start, then line end, when programmed values collide.
- R5: When the frame-end value is 0xFF, a marker whose tag matches none of the other three values is taken as a frame end.
- R6: When the frame-end value is not 0xFF, a marker with an unmatched tag causes no pulse and no state change, and none of its bytes is forwarded.
- R7: After reset or enable, nothing is forwarded and no pulse is given until a frame-end marker has been followed by a frame-start marker. A frame start seen before any frame end is ignored.
- R8: A valid byte is forwarded on outByte/outValid one cycle after it is sampled, only inside a line of an active frame, and only if it is not 0x00, not 0xFF and not a marker tag.
- R9: Each pulse lasts one cycle, one cycle after the tag byte. frameStartPulse fires when a frame start begins a frame. frameEndPulse fires on a frame end inside a frame. lineStartPulse fires on a line start inside a frame. lineEndPulse fires on a line end inside a line.
- R10: enable low returns the decoder to the disarmed state and drops any partial preamble. Bytes sampled while enable is low produce no output and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Decoder enable; low disarms it |
| inByte | input | 8 | Incoming camera byte |
| inValid | input | 1 | inByte holds a byte this cycle |
| cfgFrameStart | input | 8 | Tag value for frame start |
| cfgFrameEnd | input | 8 | Tag value for frame end (0xFF = wildcard) |
| cfgLineStart | input | 8 | Tag value for line start |
| cfgLineEnd | input | 8 | Tag value for line end |
| outByte | output | 8 | Forwarded pixel byte |
| outValid | output | 1 | outByte holds a pixel |
| frameStartPulse | output | 1 | Frame began |
| frameEndPulse | output | 1 | Frame ended |
| lineStartPulse | output | 1 | Line began |
| lineEndPulse | output | 1 | Line ended |

## Verification
Every result is due exactly one clock after the byte that causes it: a forwarded pixel appears one cycle after it is sampled, and an event pulse appears one cycle after its tag byte. The bench drives one byte per cycle on the falling edge and compares outputs on the following falling edge, after the single register stage has updated. A reference model in the bench predicts that cycle's outputs. It uses a preamble counter instead of a byte history. Directed sequences cover arming order, gaps inside markers, broken preambles, unmatched tags, the wildcard, tag priority and disabling mid-line. A seeded random phase mixes pixels, markers, gaps and enable drops.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef enum logic [1:0] {
    WAIT_END   = 2'd0,
    WAIT_START = 2'd1,
    IN_FRAME   = 2'd2,
    IN_LINE    = 2'd3
  } frameState_t;

  typedef struct packed {
    logic frameStart;
    logic frameEnd;
    logic lineStart;
    logic lineEnd;
  } codeEvents_t;

  typedef struct packed {
    logic pixelGate;
    logic flush;
  } ctrlStrobes_t;

endpackage

// File: rtl/embsync_datapath.sv
module embsync_datapath
  import embsync_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic [DATA_W-1:0] cfgFrameStart,
  input  logic [DATA_W-1:0] cfgFrameEnd,
  input  logic [DATA_W-1:0] cfgLineStart,
  input  logic [DATA_W-1:0] cfgLineEnd,
  input  ctrlStrobes_t      strobes,
  output codeEvents_t       events,
  output logic [DATA_W-1:0] outByte,
  output logic              outValid
);

  localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZEROS = {DATA_W{1'b0}};

  // history[0] is the newest byte, history[PRE_LEN-1] the oldest
  logic [DATA_W-1:0] history [PRE_LEN];
  logic [PRE_LEN-1:0] histOk;
  logic [PRE_LEN-1:0] stageMatch;
  logic codeHit;
  logic reservedByte;

  genvar gi;
  generate
    for (gi = 0; gi < PRE_LEN; gi++) begin : g_stage
      localparam logic [DATA_W-1:0] EXPECT = (gi == PRE_LEN - 1) ? ONES : ZEROS;
      assign stageMatch[gi] = histOk[gi] && (history[gi] == EXPECT);
      if (gi == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            history[gi] <= ZEROS;
          end else if (inValid && !strobes.flush) begin
            history[gi] <= inByte;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            history[gi] <= ZEROS;
          end else if (inValid && !strobes.flush) begin
            history[gi] <= history[gi-1];
          end
        end
      end
    end
  endgenerate

  assign codeHit      = inValid && (&stageMatch);
  assign reservedByte = (inByte == ONES) || (inByte == ZEROS);

  // A completed marker consumes its history so its bytes cannot seed another
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histOk <= '0;
    end else if (strobes.flush) begin
      histOk <= '0;
    end else if (inValid) begin
      if (codeHit) histOk <= '0;
      else         histOk <= {histOk[PRE_LEN-2:0], 1'b1};
    end
  end

  // Tag classification, fixed priority
  always_comb begin
    events = '0;
    if (codeHit) begin
      if      (inByte == cfgFrameStart) events.frameStart = 1'b1;
      else if (inByte == cfgFrameEnd)   events.frameEnd   = 1'b1;
      else if (inByte == cfgLineStart)  events.lineStart  = 1'b1;
      else if (inByte == cfgLineEnd)    events.lineEnd    = 1'b1;
      else if (cfgFrameEnd == ONES)     events.frameEnd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outByte  <= ZEROS;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid && strobes.pixelGate && !codeHit && !reservedByte;
      if (inValid) outByte <= inByte;
    end
  end

  AST_NO_RESERVED_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outByte != ONES && outByte != ZEROS)); // R8

  AST_MARKER_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    codeHit |=> !codeHit); // R2

endmodule

// File: rtl/embsync_ctrl.sv
module embsync_ctrl
  import embsync_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  codeEvents_t  events,
  output ctrlStrobes_t strobes,
  output logic         frameStartPulse,
  output logic         frameEndPulse,
  output logic         lineStartPulse,
  output logic         lineEndPulse
);

  frameState_t curState, nextState;
  codeEvents_t accepted;

  always_comb begin
    nextState = curState;
    accepted  = '0;
    if (!enable) begin
      nextState = WAIT_END;
    end else begin
      unique case (curState)
        WAIT_END: begin
          if (events.frameEnd) nextState = WAIT_START;
        end
        WAIT_START: begin
          if (events.frameStart) begin
            nextState           = IN_FRAME;
            accepted.frameStart = 1'b1;
          end
        end
        IN_FRAME: begin
          if (events.frameEnd) begin
            nextState         = WAIT_START;
            accepted.frameEnd = 1'b1;
          end else if (events.lineStart) begin
            nextState          = IN_LINE;
            accepted.lineStart = 1'b1;
          end
        end
        IN_LINE: begin
          if (events.frameEnd) begin
            nextState         = WAIT_START;
            accepted.frameEnd = 1'b1;
          end else if (events.lineStart) begin
            accepted.lineStart = 1'b1;
          end else if (events.lineEnd) begin
            nextState        = IN_FRAME;
            accepted.lineEnd = 1'b1;
          end
        end
        default: nextState = WAIT_END;
      endcase
    end
  end

  assign strobes.pixelGate = enable && (curState == IN_LINE);
  assign strobes.flush     = !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState        <= WAIT_END;
      frameStartPulse <= 1'b0;
      frameEndPulse   <= 1'b0;
      lineStartPulse  <= 1'b0;
      lineEndPulse    <= 1'b0;
    end else begin
      curState        <= nextState;
      frameStartPulse <= accepted.frameStart;
      frameEndPulse   <= accepted.frameEnd;
      lineStartPulse  <= accepted.lineStart;
      lineEndPulse    <= accepted.lineEnd;
    end
  end

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    frameStartPulse |-> (curState == IN_FRAME)); // R7

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStartPulse, frameEndPulse, lineStartPulse, lineEndPulse})); // R9

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    lineStartPulse |=> !lineStartPulse); // R9

  AST_DISABLE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (curState == WAIT_END && !frameStartPulse && !lineStartPulse)); // R10

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
  import embsync_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic [DATA_W-1:0] cfgFrameStart,
  input  logic [DATA_W-1:0] cfgFrameEnd,
  input  logic [DATA_W-1:0] cfgLineStart,
  input  logic [DATA_W-1:0] cfgLineEnd,
  output logic [DATA_W-1:0] outByte,
  output logic              outValid,
  output logic              frameStartPulse,
  output logic              frameEndPulse,
  output logic              lineStartPulse,
  output logic              lineEndPulse
);

  codeEvents_t  events;
  ctrlStrobes_t strobes;

  embsync_datapath #(
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .inByte       (inByte),
    .inValid      (inValid),
    .cfgFrameStart(cfgFrameStart),
    .cfgFrameEnd  (cfgFrameEnd),
    .cfgLineStart (cfgLineStart),
    .cfgLineEnd   (cfgLineEnd),
    .strobes      (strobes),
    .events       (events),
    .outByte      (outByte),
    .outValid     (outValid)
  );

  embsync_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .events         (events),
    .strobes        (strobes),
    .frameStartPulse(frameStartPulse),
    .frameEndPulse  (frameEndPulse),
    .lineStartPulse (lineStartPulse),
    .lineEndPulse   (lineEndPulse)
  );

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(enable)); // R10

endmodule

// File: tb/sim_embsync_decoder.sv
module sim_embsync_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inValid = 1'b0;
  logic [7:0] cfgFrameStart = 8'h80;
  logic [7:0] cfgFrameEnd   = 8'h9D;
  logic [7:0] cfgLineStart  = 8'hAB;
  logic [7:0] cfgLineEnd    = 8'hB6;
  logic [7:0] outByte;
  logic       outValid, frameStartPulse, frameEndPulse, lineStartPulse, lineEndPulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // model: preamble counter and framing state (0 wait end, 1 wait start, 2 frame, 3 line)
  int mCnt = 0;
  int mState = 0;

  always #2 clk = ~clk;

  embsync_decoder u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .inByte(inByte), .inValid(inValid),
    .cfgFrameStart(cfgFrameStart), .cfgFrameEnd(cfgFrameEnd),
    .cfgLineStart(cfgLineStart), .cfgLineEnd(cfgLineEnd),
    .outByte(outByte), .outValid(outValid),
    .frameStartPulse(frameStartPulse), .frameEndPulse(frameEndPulse),
    .lineStartPulse(lineStartPulse), .lineEndPulse(lineEndPulse)
  );

  // 0 none, 1 frame start, 2 frame end, 3 line start, 4 line end
  function automatic int classify(input logic [7:0] xy);
    if (xy == cfgFrameStart) return 1;
    if (xy == cfgFrameEnd)   return 2;
    if (xy == cfgLineStart)  return 3;
    if (xy == cfgLineEnd)    return 4;
    if (cfgFrameEnd == 8'hFF) return 2;
    return 0;
  endfunction

  function automatic logic [12:0] observed();
    return {outValid, (outValid ? outByte : 8'h00),
            frameStartPulse, frameEndPulse, lineStartPulse, lineEndPulse};
  endfunction

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got v=%0b d=%02h p=%04b expected v=%0b d=%02h p=%04b",
               tag, got[12], got[11:4], got[3:0], exp[12], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic step(input logic [7:0] b, input logic v, input logic en, input string tag);
    logic expV = 1'b0;
    logic [3:0] expP = 4'b0000;
    int ev;
    if (!en) begin
      mCnt = 0;
      mState = 0;
    end else if (v) begin
      if (mCnt == 3) begin
        mCnt = 0;
        ev = classify(b);
        case (ev)
          1: if (mState == 1) begin mState = 2; expP = 4'b1000; end
          2: begin
               if (mState >= 2) expP = 4'b0100;
               mState = 1;
             end
          3: if (mState >= 2) begin mState = 3; expP = 4'b0010; end
          4: if (mState == 3) begin mState = 2; expP = 4'b0001; end
          default: ;
        endcase
      end else begin
        expV = (mState == 3) && (b != 8'h00) && (b != 8'hFF);
        if (b == 8'hFF) mCnt = 1;
        else if (b == 8'h00 && (mCnt == 1 || mCnt == 2)) mCnt = mCnt + 1;
        else mCnt = 0;
      end
    end
    inByte = b;
    inValid = v;
    enable = en;
    @(posedge clk);
    @(negedge clk);
    check(tag, observed(), {expV, (expV ? b : 8'h00), expP});
  endtask

  task automatic px(input logic [7:0] b, input string tag);
    step(b, 1'b1, 1'b1, tag);
  endtask

  task automatic marker(input logic [7:0] xy, input string tag);
    px(8'hFF, tag); px(8'h00, tag); px(8'h00, tag); px(xy, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 in reset", observed(), 13'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", observed(), 13'd0);

    // R7: not armed: line start and pixels ignored, frame start before frame end ignored
    marker(cfgLineStart, "R7 ls before arm");
    px(8'h21, "R7 pixel before arm");
    marker(cfgFrameStart, "R7 fs before fe");
    marker(cfgLineStart, "R7 ls after early fs");
    px(8'h22, "R7 pixel after early fs");
    // arm and capture
    marker(cfgFrameEnd, "R7 arming fe");
    marker(cfgFrameStart, "R9 fs pulse");
    px(8'h33, "R8 pixel outside line");
    marker(cfgLineStart, "R9 ls pulse");
    px(8'h41, "R8 pixel"); px(8'h00, "R8 zero dropped"); px(8'hFE, "R8 pixel");
    px(8'hFF, "R8 ones dropped"); px(8'h5A, "R3 broken by pixel");
    // R2: gaps inside a marker
    px(8'hFF, "R2 gap");
    step(8'h00, 1'b0, 1'b1, "R2 idle");
    px(8'h00, "R2 gap"); px(8'h00, "R2 gap");
    step(8'h77, 1'b0, 1'b1, "R2 idle");
    px(cfgLineEnd, "R2 le after gaps");
    marker(cfgLineStart, "R9 ls again");
    // R3: restart on 0xFF
    px(8'hFF, "R3 restart"); px(8'h00, "R3 restart");
    marker(cfgLineEnd, "R3 le after restart");
    marker(cfgLineStart, "R3 ls");
    px(8'hFF, "R3 broken"); px(8'h00, "R3 broken"); px(8'h12, "R3 broken pixel");
    px(8'h00, "R3 broken"); px(cfgLineEnd, "R3 tag value as pixel");
    // R6: unmatched tag ignored inside a line
    marker(8'h55, "R6 unmatched");
    px(8'h66, "R6 line continues");
    marker(cfgLineEnd, "R9 le pulse");
    // R5: wildcard frame end
    @(negedge clk) cfgFrameEnd = 8'hFF;
    marker(8'h55, "R5 wildcard fe");
    marker(cfgFrameStart, "R5 restart frame");
    marker(8'h3C, "R5 wildcard fe");
    // R4: priority when values collide
    @(negedge clk) begin cfgFrameEnd = 8'h9D; cfgLineStart = 8'h80; end
    marker(8'h80, "R4 fs wins over ls");
    marker(8'h80, "R4 shared value in frame");
    @(negedge clk) cfgLineStart = 8'h9D;
    marker(8'h9D, "R4 fe wins over ls");
    @(negedge clk) cfgLineStart = 8'hAB;
    // R10: disable mid-line
    marker(cfgFrameStart, "R10 setup");
    marker(cfgLineStart, "R10 setup");
    px(8'hFF, "R10 partial"); px(8'h00, "R10 partial");
    step(8'h44, 1'b1, 1'b0, "R10 disabled byte");
    px(8'h00, "R10 partial dropped"); px(cfgLineStart, "R10 not a marker");
    px(8'h45, "R10 disarmed pixel");
    marker(cfgFrameStart, "R10 fs needs fe");

    // random phase
    for (int blk = 0; blk < 12; blk++) begin
      @(negedge clk);
      cfgFrameStart = 8'h10 + 8'($urandom_range(0, 15));
      cfgFrameEnd   = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'h30 + 8'($urandom_range(0, 15));
      cfgLineStart  = 8'h50 + 8'($urandom_range(0, 15));
      cfgLineEnd    = 8'h70 + 8'($urandom_range(0, 15));
      for (int k = 0; k < 250; k++) begin
        int r = $urandom_range(0, 99);
        if (r < 55) px(8'($urandom_range(1, 254)), "R8 random pixel");
        else if (r < 75) begin
          int s = $urandom_range(0, 4);
          logic [7:0] xy;
          case (s)
            0: xy = cfgFrameStart;
            1: xy = cfgFrameEnd;
            2: xy = cfgLineStart;
            3: xy = cfgLineEnd;
            default: xy = 8'($urandom_range(1, 254));
          endcase
          marker(xy, "R9 random marker");
        end
        else if (r < 82) px(($urandom_range(0, 1) == 0) ? 8'hFF : 8'h00, "R3 random reserved");
        else if (r < 97) step(8'($urandom), 1'b0, 1'b1, "R2 random idle");
        else step(8'($urandom), 1'b1, 1'b0, "R10 random disable");
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule